// File: doc/BRIEF.md
# Interrupt Mapping and Dispatch Controller

This block gathers 64 level-sensitive interrupt lines and forwards at most one of them at a time, as a single high line on a 64-bit one-hot request vector. Lines 0 to 31 come from expansion slots and are handled in groups of four. Each group shares one mapping register. Lines 32 to 63 come from on-board devices, and each of them has a mapping register of its own. Each mapping register holds an enable bit in bit 31 and a fixed 31-bit tag below it.

A request, once raised, stays on its output line until software clears it or disables its mapping. While a request is held, the controller keeps reasserting it. When no request is held, it picks the lowest-numbered pending input that is enabled, so slot lines always win over on-board lines. A slot line that rises with its mapping enabled replaces the held request at once. An on-board line that rises has to wait until the controller is idle.

Software uses a plain register port with a write strobe and a read strobe. Read data arrives one clock after the read strobe.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: Synchronous active-high reset clears every enable bit, the pending inputs and the held request, so `req_out` reads zero after it.
- R2: A read of the word at 0xC04+8n returns {enable, 0x7C0 | n<<2} for slot group n (0 to 7). A read of the word at 0x1004+8n returns {enable, 0x7E0 + n} for on-board source 32+n (n 0 to 31). The enable is bit 31.
- R3: A write to a mapping word changes only bit 31. The lower 31 bits always read back their fixed tag.
- R4: At most one `req_out` line is high. A held request keeps its line high, unchanged, until something removes or replaces it.
- R5: Slot input i is governed by group register i/4. When it rises with that group enabled, `req_out` becomes 1<<i one clock later, even if another request is held. When several slot lines rise together, the lowest-numbered one wins.
- R6: On-board input 32+n is governed by register n. When it rises while enabled, it is raised only if no request is held. Otherwise it stays pending.
- R7: A falling input clears its pending state but does not withdraw a held request.
- R8: While idle, and after every write, the controller selects the lowest-numbered input that is pending and enabled, so slot inputs come before on-board inputs. Enabling a mapping for a source that is already pending raises it if the controller is idle.
- R9: A mapping write with bit 31 clear drops a held request that belongs to that register: any of the four slot lines of the group, or the one on-board source.
- R10: A write to a +4 word in 0x1400 to 0x14FF selects slot group (addr&0xFF)>>5. It clears the held request if that request is a slot line in that group, and a rescan follows.
- R11: A write to 0x1804+8n clears the held request if it is on-board source 32+n, and a rescan follows.
- R12: A clear write that matches no held request has no effect. Writes to unused offsets, or to the +0 words, are ignored, and reads of them return zero.
- R13: Any request change appears on `req_out` one clock after the input or write that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Level interrupt inputs: 0-31 slot lines, 32-63 on-board lines |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid one clock after `reg_re` |
| req_out | output | 64 | One-hot forwarded request |

## Verification
The bench goes after the ordering rules.

- **Slot preemption over an on-board request.** A design that let on-board lines preempt, or that refused slot preemption, would leave the wrong line high.
- **Held on-board request versus a newly enabled lower-numbered source.** A design that rescanned while busy would move the request.
- **Re-raise of a line that is still asserted after its clear.** This is why each sweep lowers the input before clearing. A design that never rescanned would fall silent.
- **Group-wide slot clears against non-matching clears, and disables that hit any line of a group.** A design that compared the group index with the source number would drop the wrong request or keep a stale one.
- **Tag bits surviving all-ones writes, and ignored +0 words.** These catch a register that stores the full write word.

// File: rtl/irqd_pkg.sv
`timescale 1ns/1ps
package irqd_pkg;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 32;

  // register windows (byte offsets)
  localparam logic [ADDR_W-1:0] PCI_MAP_BASE = 16'h0C00;
  localparam logic [ADDR_W-1:0] DEV_MAP_BASE = 16'h1000;
  localparam logic [ADDR_W-1:0] PCI_CLR_BASE = 16'h1400;
  localparam logic [ADDR_W-1:0] DEV_CLR_BASE = 16'h1800;

  // fixed low bits of mapping registers
  localparam logic [DATA_W-2:0] PCI_TAG = 31'h7C0;
  localparam logic [DATA_W-2:0] DEV_TAG = 31'h7E0;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PCI_MAP,
    RG_DEV_MAP,
    RG_PCI_CLR,
    RG_DEV_CLR
  } region_e;

  function automatic logic in_win(input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:0] base,
                                  input int unsigned span);
    int unsigned ai;
    int unsigned bi;
    ai = {16'b0, a};
    bi = {16'b0, base};
    return (ai >= bi) && (ai < bi + span);
  endfunction

  function automatic region_e decode_region(input logic [ADDR_W-1:0] a,
                                            input int unsigned n_pmap,
                                            input int unsigned n_dev);
    region_e r;
    r = RG_NONE;
    if (a[2]) begin
      if (in_win(a, PCI_MAP_BASE, 8 * n_pmap))       r = RG_PCI_MAP;
      else if (in_win(a, DEV_MAP_BASE, 8 * n_dev))   r = RG_DEV_MAP;
      else if (in_win(a, PCI_CLR_BASE, 32 * n_pmap)) r = RG_PCI_CLR;
      else if (in_win(a, DEV_CLR_BASE, 8 * n_dev))   r = RG_DEV_CLR;
    end
    return r;
  endfunction

endpackage

// File: rtl/irqd_lowest.sv
`timescale 1ns/1ps
module irqd_lowest #(
  parameter int unsigned W = 64,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/irqd_reg_file.sv
`timescale 1ns/1ps
module irqd_reg_file
  import irqd_pkg::*;
#(
  parameter int unsigned N_PMAP = 8,
  parameter int unsigned N_DEV  = 32,
  localparam int unsigned PMW = (N_PMAP > 1) ? $clog2(N_PMAP) : 1,
  localparam int unsigned DVW = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [N_PMAP-1:0] pci_en_q,
  output logic [N_DEV-1:0]  dev_en_q,
  output logic [N_PMAP-1:0] pci_en_nx,
  output logic [N_DEV-1:0]  dev_en_nx,
  output logic              kill_grp_v,
  output logic [PMW-1:0]    kill_grp,
  output logic              kill_dev_v,
  output logic [DVW-1:0]    kill_dev
);

  region_e        rgn;
  logic [PMW-1:0] pci_sel;
  logic [DVW-1:0] dev_sel;
  logic [PMW-1:0] clr_grp;
  logic [DVW-1:0] clr_dev;
  logic           en_bit;
  logic           unused_wdata_low;

  assign en_bit           = reg_wdata[DATA_W-1];
  assign unused_wdata_low = ^reg_wdata[DATA_W-2:0];

  always_comb begin
    rgn     = decode_region(reg_addr, N_PMAP, N_DEV);
    pci_sel = PMW'((reg_addr - PCI_MAP_BASE) >> 3);
    dev_sel = DVW'((reg_addr - DEV_MAP_BASE) >> 3);
    clr_grp = PMW'((reg_addr - PCI_CLR_BASE) >> 5);
    clr_dev = DVW'((reg_addr - DEV_CLR_BASE) >> 3);
  end

  // next enable state and removal events
  always_comb begin
    pci_en_nx  = pci_en_q;
    dev_en_nx  = dev_en_q;
    kill_grp_v = 1'b0;
    kill_grp   = clr_grp;
    kill_dev_v = 1'b0;
    kill_dev   = clr_dev;
    if (reg_we) begin
      unique case (rgn)
        RG_PCI_MAP: begin
          pci_en_nx[pci_sel] = en_bit;
          kill_grp_v         = !en_bit;
          kill_grp           = pci_sel;
        end
        RG_DEV_MAP: begin
          dev_en_nx[dev_sel] = en_bit;
          kill_dev_v         = !en_bit;
          kill_dev           = dev_sel;
        end
        RG_PCI_CLR: kill_grp_v = 1'b1;
        RG_DEV_CLR: kill_dev_v = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pci_en_q <= '0;
      dev_en_q <= '0;
    end else begin
      pci_en_q <= pci_en_nx;
      dev_en_q <= dev_en_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_re) begin
      unique case (rgn)
        RG_PCI_MAP: reg_rdata <= {pci_en_q[pci_sel], PCI_TAG | ((DATA_W-1)'(pci_sel) << 2)};
        RG_DEV_MAP: reg_rdata <= {dev_en_q[dev_sel], DEV_TAG + (DATA_W-1)'(dev_sel)};
        default:    reg_rdata <= '0;
      endcase
    end
  end

  assert_unused_reads_zero_R12: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_re) && ($past(rgn) != RG_PCI_MAP) && ($past(rgn) != RG_DEV_MAP))
      |-> (reg_rdata == '0));

  assert_tag_kept_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_re) && ($past(rgn) == RG_PCI_MAP))
      |-> (reg_rdata[DATA_W-2:0] == (PCI_TAG | ((DATA_W-1)'($past(pci_sel)) << 2))));

endmodule

// File: rtl/irqd_request.sv
`timescale 1ns/1ps
module irqd_request #(
  parameter int unsigned N_PCI   = 32,
  parameter int unsigned PCI_GRP = 4,
  parameter int unsigned N_DEV   = 32,
  localparam int unsigned N_SRC  = N_PCI + N_DEV,
  localparam int unsigned N_PMAP = N_PCI / PCI_GRP,
  localparam int unsigned IW     = $clog2(N_SRC),
  localparam int unsigned GSH    = $clog2(PCI_GRP),
  localparam int unsigned PMW    = (N_PMAP > 1) ? $clog2(N_PMAP) : 1,
  localparam int unsigned DVW    = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_in,
  input  logic [N_SRC-1:0] src_en_nx,
  input  logic [N_SRC-1:0] src_en_q,
  input  logic             kill_grp_v,
  input  logic [PMW-1:0]   kill_grp,
  input  logic             kill_dev_v,
  input  logic [DVW-1:0]   kill_dev,
  output logic [N_SRC-1:0] req_out
);

  localparam logic [N_SRC-1:0] PCI_MASK = {{N_DEV{1'b0}}, {N_PCI{1'b1}}};

  logic [N_SRC-1:0] pend_q;
  logic             req_v;
  logic [IW-1:0]    req_idx;

  logic [N_SRC-1:0] rise;
  logic [N_SRC-1:0] pci_hot;
  logic [N_SRC-1:0] scan_vec;
  logic             hot_any, scan_any;
  logic [IW-1:0]    hot_idx, scan_idx;
  logic             req_is_pci;
  logic             kill_hit;
  logic             nxt_v;
  logic [IW-1:0]    nxt_idx;

  assign rise     = irq_in & ~pend_q;
  assign pci_hot  = rise & src_en_nx & PCI_MASK;
  assign scan_vec = irq_in & src_en_nx;

  irqd_lowest #(.W(N_SRC)) u_hot (
    .vec(pci_hot), .found(hot_any), .idx(hot_idx)
  );

  irqd_lowest #(.W(N_SRC)) u_scan (
    .vec(scan_vec), .found(scan_any), .idx(scan_idx)
  );

  always_comb begin
    req_is_pci = req_idx < IW'(N_PCI);
    kill_hit   = req_v &&
                 ((kill_grp_v && req_is_pci && ((req_idx >> GSH) == IW'(kill_grp))) ||
                  (kill_dev_v && (req_idx == IW'(N_PCI) + IW'(kill_dev))));
  end

  always_comb begin
    nxt_v   = 1'b0;
    nxt_idx = req_idx;
    if (hot_any) begin
      nxt_v   = 1'b1;
      nxt_idx = hot_idx;
    end else if (req_v && !kill_hit) begin
      nxt_v   = 1'b1;
    end else if (scan_any) begin
      nxt_v   = 1'b1;
      nxt_idx = scan_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      req_v   <= 1'b0;
      req_idx <= '0;
      req_out <= '0;
    end else begin
      pend_q  <= irq_in;
      req_v   <= nxt_v;
      req_idx <= nxt_idx;
      req_out <= '0;
      if (nxt_v) req_out[nxt_idx] <= 1'b1;
    end
  end

  assert_single_line_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_out));

  assert_held_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (req_v && !kill_grp_v && !kill_dev_v && !(|(rise & src_en_nx & PCI_MASK)))
      |=> $stable(req_out));

  assert_enabled_only_R8: assert property (@(posedge clk) disable iff (rst)
    (|req_out) |-> ((req_out & src_en_q) == req_out));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (!req_v && !(|(irq_in & src_en_nx))) |=> (req_out == '0));

endmodule

// File: rtl/irq_dispatch_ctrl.sv
`timescale 1ns/1ps
module irq_dispatch_ctrl
  import irqd_pkg::*;
#(
  parameter int unsigned N_PCI   = 32,
  parameter int unsigned PCI_GRP = 4,
  parameter int unsigned N_DEV   = 32,
  localparam int unsigned N_SRC  = N_PCI + N_DEV,
  localparam int unsigned N_PMAP = N_PCI / PCI_GRP,
  localparam int unsigned PMW    = (N_PMAP > 1) ? $clog2(N_PMAP) : 1,
  localparam int unsigned DVW    = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [N_SRC-1:0]  req_out
);

  logic [N_PMAP-1:0] pci_en_q, pci_en_nx;
  logic [N_DEV-1:0]  dev_en_q, dev_en_nx;
  logic [N_SRC-1:0]  src_en_q, src_en_nx;
  logic              kill_grp_v, kill_dev_v;
  logic [PMW-1:0]    kill_grp;
  logic [DVW-1:0]    kill_dev;

  irqd_reg_file #(.N_PMAP(N_PMAP), .N_DEV(N_DEV)) u_regs (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pci_en_q(pci_en_q), .dev_en_q(dev_en_q),
    .pci_en_nx(pci_en_nx), .dev_en_nx(dev_en_nx),
    .kill_grp_v(kill_grp_v), .kill_grp(kill_grp),
    .kill_dev_v(kill_dev_v), .kill_dev(kill_dev)
  );

  // fan mapping enables out to sources
  for (genvar i = 0; i < N_SRC; i++) begin : g_src_en
    if (i < N_PCI) begin : g_pci
      assign src_en_q[i]  = pci_en_q[i / PCI_GRP];
      assign src_en_nx[i] = pci_en_nx[i / PCI_GRP];
    end else begin : g_dev
      assign src_en_q[i]  = dev_en_q[i - N_PCI];
      assign src_en_nx[i] = dev_en_nx[i - N_PCI];
    end
  end

  irqd_request #(.N_PCI(N_PCI), .PCI_GRP(PCI_GRP), .N_DEV(N_DEV)) u_req (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .src_en_nx(src_en_nx), .src_en_q(src_en_q),
    .kill_grp_v(kill_grp_v), .kill_grp(kill_grp),
    .kill_dev_v(kill_dev_v), .kill_dev(kill_dev),
    .req_out(req_out)
  );

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((req_out == '0) && (pci_en_q == '0) && (dev_en_q == '0)));

endmodule

// File: tb/irq_dispatch_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_dispatch_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq = '0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] req_out;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] rd_val;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_dispatch_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_in(irq), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_out(req_out)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    reg_addr = a; reg_re = 1'b1;
    step();
    reg_re = 1'b0;
    rd_val = reg_rdata;
  endtask

  task automatic setin(input int i, input logic v);
    irq[i] = v;
    step();
  endtask

  task automatic chk_req(input string tag, input logic [63:0] exp);
    n_checks++;
    if (req_out !== exp) begin
      n_fail++;
      $display("FAIL %s req_out actual=%h expected=%h", tag, req_out, exp);
    end
  endtask

  task automatic chk_rd(input string tag, input logic [15:0] a, input logic [31:0] exp);
    rd(a);
    n_checks++;
    if (rd_val !== exp) begin
      n_fail++;
      $display("FAIL %s read %h actual=%h expected=%h", tag, a, rd_val, exp);
    end
  endtask

  function automatic logic [63:0] bitv(input int i);
    return 64'(1) << i;
  endfunction

  function automatic logic [31:0] pci_word(input int n, input logic en);
    return {en, 31'h7C0 | 31'(n << 2)};
  endfunction

  function automatic logic [31:0] dev_word(input int n, input logic en);
    return {en, 31'h7E0 + 31'(n)};
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk_req("R1 reset", '0);
    chk_rd("R1 enable cleared", 16'h0C04, pci_word(0, 1'b0));

    // R2 readback sweep
    for (int n = 0; n < 8; n++) begin
      chk_rd("R2 slot map", 16'(16'h0C04 + 8 * n), pci_word(n, 1'b0));
      chk_rd("R12 plus0 word", 16'(16'h0C00 + 8 * n), 32'h0);
    end
    for (int n = 0; n < 32; n++)
      chk_rd("R2 dev map", 16'(16'h1004 + 8 * n), dev_word(n, 1'b0));

    // R3 all-ones write touches only bit 31
    for (int n = 0; n < 8; n++) begin
      wr(16'(16'h0C04 + 8 * n), 32'hFFFF_FFFF);
      chk_rd("R3 slot tag kept", 16'(16'h0C04 + 8 * n), pci_word(n, 1'b1));
    end

    // R5/R7/R10 slot sweep
    for (int i = 0; i < 32; i++) begin
      setin(i, 1'b1);
      chk_req("R5 R13 slot raise", bitv(i));
      setin(i, 1'b0);
      chk_req("R7 fall keeps", bitv(i));
      wr(16'(16'h1404 + 32 * (i / 4)), 32'h0);
      chk_req("R10 group clear", '0);
    end

    // R5 simultaneous slot rises, lowest wins
    irq[20] = 1'b1; irq[17] = 1'b1;
    step();
    chk_req("R5 lowest of simultaneous", bitv(17));
    irq[20] = 1'b0; irq[17] = 1'b0;
    step();
    wr(16'h1484, 32'h0);
    chk_req("R10 clear group 4", '0);

    // R6/R11 on-board sweep
    for (int n = 0; n < 32; n++) begin
      wr(16'(16'h1004 + 8 * n), 32'h8000_0000);
      chk_rd("R3 dev tag kept", 16'(16'h1004 + 8 * n), dev_word(n, 1'b1));
      setin(32 + n, 1'b1);
      chk_req("R6 dev raise", bitv(32 + n));
      setin(32 + n, 1'b0);
      chk_req("R7 dev fall keeps", bitv(32 + n));
      wr(16'(16'h1804 + 8 * n), 32'h0);
      chk_req("R11 dev clear", '0);
    end

    // R6 no preempt by on-board, R5 slot preempt, R12 non-matching clears
    setin(33, 1'b1);
    chk_req("R6 dev 33", bitv(33));
    setin(34, 1'b1);
    chk_req("R6 dev 34 waits", bitv(33));
    setin(9, 1'b1);
    chk_req("R5 slot preempts", bitv(9));
    wr(16'h1424, 32'h0);
    chk_req("R12 wrong group clear", bitv(9));
    wr(16'h180C, 32'h0);
    chk_req("R12 wrong dev clear", bitv(9));
    setin(9, 1'b0);
    chk_req("R7 slot fall keeps", bitv(9));
    wr(16'h1444, 32'h0);
    chk_req("R8 rescan after group clear", bitv(33));
    setin(33, 1'b0);
    wr(16'h180C, 32'h0);
    chk_req("R8 rescan after dev clear", bitv(34));
    wr(16'h1804, 32'h0);
    chk_req("R12 dev clear mismatch", bitv(34));
    setin(34, 1'b0);
    wr(16'h1814, 32'h0);
    chk_req("R11 final clear", '0);

    // R9 disable drops, R8 enable rescans
    setin(40, 1'b1);
    chk_req("R6 dev 40", bitv(40));
    wr(16'h1044, 32'h0);
    chk_req("R9 dev disable drops", '0);
    wr(16'h1044, 32'h8000_0000);
    chk_req("R8 enable raises pending", bitv(40));
    wr(16'h1044, 32'h0);
    chk_req("R9 dev disable again", '0);
    setin(40, 1'b0);
    setin(13, 1'b1);
    chk_req("R5 slot 13", bitv(13));
    wr(16'h0C1C, 32'h0);
    chk_req("R9 group disable drops", '0);
    setin(13, 1'b0);

    // R8 ordering with held request
    wr(16'h106C, 32'h0);
    wr(16'h10E4, 32'h0);
    setin(60, 1'b1);
    setin(45, 1'b1);
    setin(12, 1'b1);
    chk_req("R8 disabled pending idle", '0);
    wr(16'h10E4, 32'h8000_0000);
    chk_req("R8 enable picks 60", bitv(60));
    wr(16'h106C, 32'h8000_0000);
    chk_req("R8 held not rescanned", bitv(60));
    wr(16'h0C1C, 32'h8000_0000);
    chk_req("R8 held vs slot enable", bitv(60));
    setin(60, 1'b0);
    wr(16'h18E4, 32'h0);
    chk_req("R8 slot before dev", bitv(12));
    setin(12, 1'b0);
    wr(16'h1464, 32'h0);
    chk_req("R8 next dev", bitv(45));
    setin(45, 1'b0);
    wr(16'h186C, 32'h0);
    chk_req("R11 idle", '0);

    // R12 unused offsets and +0 words
    wr(16'h2000, 32'hFFFF_FFFF);
    chk_rd("R12 unused read", 16'h2000, 32'h0);
    wr(16'h0C00, 32'h0);
    chk_rd("R12 plus0 write ignored", 16'h0C04, pci_word(0, 1'b1));
    chk_rd("R12 clear word reads zero", 16'h1404, 32'h0);

    // R1 reset in operation
    setin(5, 1'b1);
    chk_req("R5 slot 5", bitv(5));
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk_req("R1 reset drops request", '0);
    step();
    chk_req("R1 disabled after reset", '0);
    chk_rd("R1 slot enable cleared", 16'h0C04, pci_word(0, 1'b0));
    chk_rd("R1 dev enable cleared", 16'h1004, dev_word(0, 1'b0));
    setin(5, 1'b0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule